// File: doc/BRIEF.md
# Flash Read-While-Write Stall/Abort Controller

This block sits between a bus read port and a flash program/erase engine that serves two banks. When a read targets a bank that is idle, the read goes to the array one cycle later. When the read targets a bank that is in the middle of a program or erase, the block holds the read, drops its ready line, and sends the held read on by itself once the bank is free again. Each bank's 3-bit mode selects whether such a collision only stalls the read or also aborts the running operation, and whether a notification flag is raised.

An abort request for a bank stays asserted until the engine reports done for that bank. Four sticky notification flags, a stall flag and an abort flag per bank, sit in an 8-bit register at fixed bit positions and are cleared by writing ones to them. Their OR drives a single interrupt line. The bus master issues one read at a time and presents a new one only while the ready line is high.

Top module: `rww_guard`

## Requirements
- R1: After a synchronous reset, rd_ready is 1, while rd_issue, abort_req, note_flags and irq are all 0.
- R2: An accepted read whose bank (rd_addr bit 15: 0 is bank 0, 1 is bank 1) has pe_busy low is issued on rd_issue in the next cycle with the same address. rd_ready stays high, and no flag or abort is raised. This holds even while the other bank is busy.
- R3: An accepted read whose bank has pe_busy high is captured and rd_ready goes low. rd_issue stays low for as long as that bank stays busy. In the cycle after busy falls, the captured address is issued and rd_ready returns high.
- R4: In mode 3'b100, a collision sets abort_req for that bank from the next cycle and sets that bank's abort flag. abort_req stays high until the cycle after pe_done is seen.
- R5: In mode 3'b010, a collision asserts and holds abort_req the same way as in R4 but sets no flag.
- R6: In mode 3'b001, a collision stalls the read, sets that bank's stall flag and asserts no abort.
- R7: Mode 3'b000 and every unlisted encoding (3'b011, 3'b101, 3'b110, 3'b111) stall the read with no flag and no abort.
- R8: The flag positions in note_flags are: bit 7 is the bank 0 abort flag, bit 6 the bank 0 stall flag, bit 5 the bank 1 abort flag and bit 4 the bank 1 stall flag. Bits 3..0 read as 0.
- R9: Flags are sticky. A reg_wr cycle clears each flag whose reg_wdata bit is 1 and leaves flags at 0 bits untouched. A set in the same cycle wins over the clear.
- R10: irq equals the OR of the four flags and changes in the same cycle as they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, accepted when rd_ready is high |
| rd_addr | input | 16 | Read address; bit 15 selects the bank |
| rd_ready | output | 1 | Low while a captured read waits for its bank |
| rd_issue | output | 1 | One-cycle pulse: read forwarded to the array |
| rd_issue_addr | output | 16 | Address of the forwarded read |
| mode_b0 | input | 3 | Collision mode for bank 0 |
| mode_b1 | input | 3 | Collision mode for bank 1 |
| pe_busy | input | 2 | Per-bank program/erase in progress |
| pe_done | input | 2 | Per-bank operation finished |
| abort_req | output | 2 | Per-bank abort request, held until done |
| reg_wr | input | 1 | Flag register write strobe |
| reg_wdata | input | 8 | Write-one-to-clear data |
| note_flags | output | 8 | Sticky notification flags |
| irq | output | 1 | OR of all notification flags |

## Verification
Reads go to an idle bank and to the free bank while the other one is busy. Both must pass straight through, which separates a bank-aware decision from a global stall. Colliding reads are run under each defined mode and under every unlisted encoding. The set of flags and aborts that follows tells the stall, abort and silent behaviours apart. Each colliding read is held across several busy cycles before release, which shows the difference between a real retry and an early issue or a lost read. Wrong-bit and simultaneous set/clear writes then separate write-one-to-clear from plain overwrite.

// File: rtl/rww_pkg.sv
package rww_pkg;

  typedef enum logic [2:0] {
    RWW_STALL       = 3'b000,
    RWW_STALL_NOTE  = 3'b001,
    RWW_ABORT_QUIET = 3'b010,
    RWW_ABORT_NOTE  = 3'b100
  } rww_mode_e;

  typedef struct packed {
    logic stall_note;
    logic abort;
    logic abort_note;
  } rww_act_t;

  function automatic rww_act_t rww_decode(input logic [2:0] m);
    rww_act_t a;
    a = '0;
    case (m)
      RWW_STALL_NOTE:  a.stall_note = 1'b1;
      RWW_ABORT_QUIET: a.abort      = 1'b1;
      RWW_ABORT_NOTE:  begin a.abort = 1'b1; a.abort_note = 1'b1; end
      default:         a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/rww_bank_ctl.sv
module rww_bank_ctl
  import rww_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       collide,
  input  logic       done,
  output logic       abort_q,
  output logic       set_abort,
  output logic       set_stall
);

  rww_act_t act;

  always_comb begin
    act       = rww_decode(mode);
    set_abort = collide && act.abort_note;
    set_stall = collide && act.stall_note;
  end

  always_ff @(posedge clk) begin
    if (rst)                      abort_q <= 1'b0;
    else if (collide && act.abort) abort_q <= 1'b1;
    else if (done)                abort_q <= 1'b0;
  end

  // R4 / R5: abort stays up until done is seen
  a_r5_abort_held: assert property (@(posedge clk) disable iff (rst)
    abort_q && !done |=> abort_q);
  a_r4_abort_release: assert property (@(posedge clk) disable iff (rst)
    abort_q && done && !collide |=> !abort_q);

endmodule

// File: rtl/rww_read_track.sv
module rww_read_track #(
  parameter int ADDR_W   = 16,
  parameter int BANK_BIT = 15,
  parameter int NBANK    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBANK-1:0]  busy,
  output logic              rd_ready,
  output logic              rd_issue,
  output logic [ADDR_W-1:0] rd_issue_addr,
  output logic [NBANK-1:0]  collide
);

  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [BSEL_W-1:0] in_bank, pend_bank;
  logic              accept;

  always_comb begin
    in_bank   = rd_addr[BANK_BIT -: BSEL_W];
    pend_bank = pend_addr_q[BANK_BIT -: BSEL_W];
    accept    = rd_req && !pend_q;
    collide   = '0;
    if (accept && busy[in_bank]) collide[in_bank] = 1'b1;
  end

  assign rd_ready = !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= 1'b0;
      pend_addr_q   <= '0;
      rd_issue      <= 1'b0;
      rd_issue_addr <= '0;
    end else begin
      rd_issue <= 1'b0;
      if (pend_q) begin
        if (!busy[pend_bank]) begin
          rd_issue      <= 1'b1;
          rd_issue_addr <= pend_addr_q;
          pend_q        <= 1'b0;
        end
      end else if (accept) begin
        if (busy[in_bank]) begin
          pend_q      <= 1'b1;
          pend_addr_q <= rd_addr;
        end else begin
          rd_issue      <= 1'b1;
          rd_issue_addr <= rd_addr;
        end
      end
    end
  end

  // R3: a held read waits while its bank is busy, then goes out
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    pend_q && busy[pend_bank] |=> pend_q && !rd_issue);
  a_r3_retry: assert property (@(posedge clk) disable iff (rst)
    pend_q && !busy[pend_bank] |=> rd_issue && (rd_issue_addr == $past(pend_addr_q)));

endmodule

// File: rtl/rww_note_reg.sv
module rww_note_reg #(
  parameter int REG_W = 8,
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] set_abort,
  input  logic [NBANK-1:0] set_stall,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] flags_q,
  output logic             irq
);

  localparam int TOP = REG_W - 1;

  logic [REG_W-1:0] set_vec, clr_vec, flags_n;

  always_comb begin
    set_vec = '0;
    for (int b = 0; b < NBANK; b++) begin
      set_vec[TOP - 2*b]     = set_abort[b];
      set_vec[TOP - 2*b - 1] = set_stall[b];
    end
    clr_vec = reg_wr ? reg_wdata : '0;
    flags_n = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_n;
      irq     <= |flags_n;
    end
  end

  // R9: a flag not cleared this cycle survives
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(flags_q) & ~$past(clr_vec)) & ~flags_q)) == '0));
  // R10: interrupt tracks the flags
  a_r10_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags_q));

endmodule

// File: rtl/rww_guard.sv
module rww_guard #(
  parameter int ADDR_W   = 16,
  parameter int BANK_BIT = 15,
  parameter int REG_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_issue,
  output logic [ADDR_W-1:0] rd_issue_addr,
  input  logic [2:0]        mode_b0,
  input  logic [2:0]        mode_b1,
  input  logic [1:0]        pe_busy,
  input  logic [1:0]        pe_done,
  output logic [1:0]        abort_req,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  note_flags,
  output logic              irq
);

  localparam int NBANK = 2;

  logic [NBANK-1:0] collide, set_abort, set_stall;
  logic [2:0]       mode_arr [NBANK];

  assign mode_arr[0] = mode_b0;
  assign mode_arr[1] = mode_b1;

  rww_read_track #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .NBANK(NBANK)) u_track (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .busy(pe_busy),
    .rd_ready(rd_ready), .rd_issue(rd_issue), .rd_issue_addr(rd_issue_addr),
    .collide(collide)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rww_bank_ctl u_bank (
      .clk(clk), .rst(rst), .mode(mode_arr[b]), .collide(collide[b]),
      .done(pe_done[b]), .abort_q(abort_req[b]),
      .set_abort(set_abort[b]), .set_stall(set_stall[b])
    );
  end

  rww_note_reg #(.REG_W(REG_W), .NBANK(NBANK)) u_note (
    .clk(clk), .rst(rst), .set_abort(set_abort), .set_stall(set_stall),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .flags_q(note_flags), .irq(irq)
  );

  // R2: an issued read never leaves while the block is holding one
  a_r2_issue_ready: assert property (@(posedge clk) disable iff (rst)
    rd_issue |-> rd_ready);

endmodule

// File: tb/rww_guard_bench.sv
module rww_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_ready, rd_issue, irq;
  logic [15:0] rd_issue_addr;
  logic [2:0]  mode_b0 = 3'b000, mode_b1 = 3'b000;
  logic [1:0]  pe_busy = '0, pe_done = '0, abort_req;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0, note_flags;

  int checks = 0, errors = 0;
  bit done_run = 0;
  logic [15:0] exp_q [$];

  always #5 clk = ~clk;

  rww_guard u_rww_guard (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_issue(rd_issue), .rd_issue_addr(rd_issue_addr),
    .mode_b0(mode_b0), .mode_b1(mode_b1), .pe_busy(pe_busy), .pe_done(pe_done),
    .abort_req(abort_req), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .note_flags(note_flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: R2/R3 issued reads must match the scoreboard in order
  always @(negedge clk) begin
    if (!rst && rd_issue && !done_run) begin
      if (exp_q.size() == 0) chk(0, "R2/R3 unexpected issue", {16'h0, rd_issue_addr}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_issue_addr == e, "R2/R3 issue addr", {16'h0, rd_issue_addr}, {16'h0, e});
      end
    end
  end

  task automatic rd(input logic [15:0] a);
    exp_q.push_back(a);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic release_bank(input int b);
    pe_busy[b] = 1'b0; pe_done[b] = 1'b1;
    @(negedge clk);
    pe_done[b] = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run;
    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_ready == 1 && rd_issue == 0, "R1 ready/issue", {rd_ready, rd_issue}, 2'b10);
    chk(abort_req == 0 && note_flags == 0 && irq == 0, "R1 abort/flags/irq", {abort_req, note_flags, irq}, 0);

    // R2 idle banks
    rd(16'h0123);
    chk(rd_ready == 1, "R2 ready stays high", rd_ready, 1);
    rd(16'h8456);
    @(negedge clk);

    // R2 other bank free while bank 0 busy (mode abort+note must not fire)
    mode_b0 = 3'b100; pe_busy = 2'b01;
    rd(16'h8777);
    chk(rd_ready == 1 && abort_req == 0 && note_flags == 0, "R2 free bank passes", {rd_ready, abort_req, note_flags}, {1'b1, 2'b0, 8'h0});

    // R4 abort with note on bank 0, R3 held, R8 bit 7, R10 irq
    rd(16'h0040);
    chk(rd_ready == 0, "R3 ready low on collision", rd_ready, 0);
    chk(abort_req == 2'b01, "R4 abort asserted", abort_req, 2'b01);
    chk(note_flags == 8'h80, "R8 bank0 abort at bit 7", note_flags, 8'h80);
    chk(irq == 1, "R10 irq with flag", irq, 1);
    for (int i = 0; i < 3; i++) begin
      chk(rd_issue == 0 && rd_ready == 0, "R3 held while busy", {rd_issue, rd_ready}, 0);
      @(negedge clk);
    end
    chk(abort_req == 2'b01, "R4 abort held until done", abort_req, 2'b01);
    release_bank(0);
    chk(abort_req == 0, "R4 abort released after done", abort_req, 0);
    chk(rd_ready == 1, "R3 ready back after retry", rd_ready, 1);

    // R9 write-0 bits untouched, write-1 clears
    wr(8'h40);
    chk(note_flags == 8'h80, "R9 other bit write keeps flag", note_flags, 8'h80);
    wr(8'h80);
    chk(note_flags == 0 && irq == 0, "R9/R10 clear by writing one", {note_flags, irq}, 0);

    // R5 silent abort on bank 1
    mode_b1 = 3'b010; pe_busy = 2'b10;
    rd(16'h8AAA);
    chk(abort_req == 2'b10, "R5 quiet abort asserted", abort_req, 2'b10);
    chk(note_flags == 0 && irq == 0, "R5 no flag", {note_flags, irq}, 0);
    repeat (4) @(negedge clk);
    chk(abort_req == 2'b10 && rd_ready == 0, "R5 abort held", {abort_req, rd_ready}, 3'b100);
    release_bank(1);
    chk(abort_req == 0, "R5 abort released", abort_req, 0);

    // R6 stall with note, bank 1 then bank 0
    mode_b1 = 3'b001; pe_busy = 2'b10;
    rd(16'h8BBB);
    chk(note_flags == 8'h10 && abort_req == 0, "R6/R8 bank1 stall at bit 4", {abort_req, note_flags}, {2'b0, 8'h10});
    repeat (2) @(negedge clk);
    release_bank(1);
    mode_b0 = 3'b001; pe_busy = 2'b01;
    rd(16'h0CCC);
    chk(note_flags == 8'h50 && abort_req == 0, "R6/R8 bank0 stall at bit 6", {abort_req, note_flags}, {2'b0, 8'h50});
    release_bank(0);

    // R9 set wins over clear in same cycle
    pe_busy = 2'b01;
    exp_q.push_back(16'h0DDD);
    rd_req = 1'b1; rd_addr = 16'h0DDD; reg_wr = 1'b1; reg_wdata = 8'h40;
    @(negedge clk);
    rd_req = 1'b0; reg_wr = 1'b0;
    chk(note_flags == 8'h50, "R9 set beats clear", note_flags, 8'h50);
    release_bank(0);
    wr(8'hF0);
    chk(note_flags == 0 && irq == 0, "R9/R10 clear all", {note_flags, irq}, 0);

    // R7 plain stall and unlisted encodings
    for (int k = 0; k < 5; k++) begin
      logic [2:0] m;
      m = (k == 0) ? 3'b000 : (k == 1) ? 3'b011 : (k == 2) ? 3'b101 : (k == 3) ? 3'b110 : 3'b111;
      mode_b0 = m; pe_busy = 2'b01;
      rd(16'h0100 + 16'(k));
      chk(rd_ready == 0 && abort_req == 0 && note_flags == 0 && irq == 0, "R7 plain stall",
          {rd_ready, abort_req, note_flags, irq}, 0);
      @(negedge clk);
      release_bank(0);
    end

    @(negedge clk);
    chk(exp_q.size() == 0, "R3 every read issued", exp_q.size(), 0);
    finish_run();
  end

endmodule